// File: doc/BRIEF.md
# Input-Line Brown-Out and Line-Range Supervisor

This block watches the health of the mains input of a boost power stage. It does not handle analog signals: it takes the outputs of comparators that sit on a low-pass filtered, scaled copy of the input voltage, plus one comparator that reports the control voltage has fallen to the skip level. From these it decides whether the stage may start switching, when it must wind down, and which loop gain suits the present line range.

Start-up is held off until the line rises above the brown-in level, and that release takes effect on the next clock. The reverse decision is slower. The line must stay below the brown-out level without a break for a programmable number of cycles. When that happens the block does not cut the drive. It enables a discharge current that ramps the control voltage down, and it asks for switching to stop only when that voltage reaches the skip level. This avoids a sudden step in line current. Line-range detection uses the same pattern. The move to high line is immediate. The move to low line needs a sustained low reading, and high line divides the loop gain by three.

All delays are parameters counted in clock cycles. A two-flop synchronizer releases the block's reset.

Top module: `blsup_top`

## Requirements
- R1: While reset is applied, and after reset until the first input takes effect, `bo_flag_o`=1 (brown-out, not OK), `ctrl_dis_en_o`=0, `sw_stop_o`=1 and `high_line_o`=1. Inputs take effect from the third rising edge after `rst_ni` goes high.
- R2: While `bo_flag_o`=1 and switching is stopped, a clock edge that samples `vs_above_bo_hi_i`=1 makes `bo_flag_o`=0 and `sw_stop_o`=0 after that edge.
- R3: While `bo_flag_o`=0, `bo_flag_o` and `ctrl_dis_en_o` go to 1 after the BO_DLY_CYC-th consecutive edge that samples `vs_below_bo_lo_i`=1 with `vs_above_bo_hi_i`=0. After one fewer such edge, nothing changes. `sw_stop_o` stays 0 at that point.
- R4: One edge that samples `vs_below_bo_lo_i`=0 (or `vs_above_bo_hi_i`=1) during the brown-out qualification restarts the count. A further BO_DLY_CYC consecutive qualifying edges are then needed.
- R5: While the control voltage ramps down (`ctrl_dis_en_o`=1), `sw_stop_o` stays 0 until an edge samples `ctrl_at_skip_i`=1. After that edge `sw_stop_o`=1, `ctrl_dis_en_o`=0 and `bo_flag_o` stays 1.
- R6: `ctrl_at_skip_i` has no effect on any output while `bo_flag_o`=0. `sw_stop_o` and `ctrl_dis_en_o` are never 1 together.
- R7: During the ramp-down, an edge that samples `vs_above_bo_hi_i`=1 with `ctrl_at_skip_i`=0 returns the block to normal running: `bo_flag_o`=0, `ctrl_dis_en_o`=0, `sw_stop_o`=0.
- R8: An edge that samples `vs_above_hl_i`=1 makes `high_line_o`=1 (loop gain divided by three) after that edge, from either state. This takes precedence over `vs_below_ll_i`.
- R9: While `high_line_o`=1, `high_line_o` goes to 0 after the LL_DLY_CYC-th consecutive edge that samples `vs_below_ll_i`=1 with `vs_above_hl_i`=0. Any edge that breaks this run restarts the count. While `high_line_o`=0, `vs_below_ll_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vs_above_bo_hi_i | input | 1 | Line sense is above the brown-in level |
| vs_below_bo_lo_i | input | 1 | Line sense is below the brown-out level |
| vs_above_hl_i | input | 1 | Line sense is above the high-line level |
| vs_below_ll_i | input | 1 | Line sense is below the low-line level |
| ctrl_at_skip_i | input | 1 | Control voltage has reached the skip level |
| bo_flag_o | output | 1 | 1 = brown-out (line not OK), 0 = line OK |
| ctrl_dis_en_o | output | 1 | Enables the discharge current on the control node |
| sw_stop_o | output | 1 | 1 = switching must be stopped |
| high_line_o | output | 1 | 1 = high line (gain divided by three), 0 = low line |

## Verification
The bench holds each below-threshold input high for one edge fewer than the delay, then breaks the run once and restarts it. A counter that saturates, or that does not clear on the break, would therefore trip early. It also drives the skip indication while the line is healthy, and during the ramp it raises the brown-in input and the skip input at different times. A design that stops the drive as soon as the flag rises, or that lets the skip input act outside the ramp, shows up as a wrong stop output. Line-range checks cover the immediate return to high line and the inert low-line input once low line is reached.

// File: rtl/blsup_pkg.sv
package blsup_pkg;
  typedef enum logic [1:0] {
    BO_BLOCKED = 2'd0,
    BO_RUN     = 2'd1,
    BO_RAMP    = 2'd2
  } bo_state_e;
endpackage

// File: rtl/blsup_rst_sync.sv
module blsup_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/blsup_qual_timer.sv
module blsup_qual_timer #(
  parameter int unsigned DLY_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DLY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          run;

  always_comb begin
    run    = en_i && cond_i;
    done_o = run && (cnt_q == LAST);
    cnt_ce = run || (cnt_q != '0);
    if (!run)        cnt_d = '0;
    else if (done_o) cnt_d = cnt_q;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R4
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && cond_i) |=> (cnt_q == '0));
endmodule

// File: rtl/blsup_bo_fsm.sv
module blsup_bo_fsm
  import blsup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_hi_i,
  input  logic lo_done_i,
  input  logic at_skip_i,
  output logic qual_en_o,
  output logic flag_o,
  output logic dis_o,
  output logic stop_o
);
  bo_state_e state_q, state_d;
  logic      state_ce;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BO_BLOCKED: if (above_hi_i) state_d = BO_RUN;
      BO_RUN:     if (lo_done_i)  state_d = BO_RAMP;
      BO_RAMP: begin
        if (at_skip_i)       state_d = BO_BLOCKED;
        else if (above_hi_i) state_d = BO_RUN;
      end
      default: state_d = BO_BLOCKED;
    endcase
    state_ce = (state_d != state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= BO_BLOCKED;
    else if (state_ce) state_q <= state_d;
  end

  always_comb begin
    qual_en_o = (state_q == BO_RUN);
    flag_o    = (state_q != BO_RUN);
    dis_o     = (state_q == BO_RAMP);
    stop_o    = (state_q == BO_BLOCKED);
  end

  // R2
  brownin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && above_hi_i && !at_skip_i) |=> !flag_o);
  // R3
  ramp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dis_o) |-> $past(!flag_o));
  // R5
  stop_on_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> ($past(at_skip_i) && $past(dis_o)));
  // R6
  dis_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dis_o && stop_o));
  // R6
  run_no_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o |=> !stop_o);
endmodule

// File: rtl/blsup_line_range.sv
module blsup_line_range #(
  parameter int unsigned LL_DLY_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_hl_i,
  input  logic below_ll_i,
  output logic high_line_o
);
  logic hl_q, hl_d, hl_ce;
  logic ll_done;
  logic ll_en;

  assign ll_en = hl_q && !above_hl_i;

  blsup_qual_timer #(.DLY_CYC(LL_DLY_CYC)) u_ll_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ll_en),
    .cond_i (below_ll_i),
    .done_o (ll_done)
  );

  always_comb begin
    hl_d = hl_q;
    if (above_hl_i)   hl_d = 1'b1;
    else if (ll_done) hl_d = 1'b0;
    hl_ce = (hl_d != hl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hl_q <= 1'b1;
    else if (hl_ce) hl_q <= hl_d;
  end

  assign high_line_o = hl_q;

  // R8
  hl_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above_hl_i |=> high_line_o);
  // R9
  ll_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(high_line_o) |-> ($past(below_ll_i) && !$past(above_hl_i)));
endmodule

// File: rtl/blsup_top.sv
module blsup_top #(
  parameter int unsigned BO_DLY_CYC = 5000000,
  parameter int unsigned LL_DLY_CYC = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_above_bo_hi_i,
  input  logic vs_below_bo_lo_i,
  input  logic vs_above_hl_i,
  input  logic vs_below_ll_i,
  input  logic ctrl_at_skip_i,
  output logic bo_flag_o,
  output logic ctrl_dis_en_o,
  output logic sw_stop_o,
  output logic high_line_o
);
  logic rst_sync_n;
  logic bo_qual_en;
  logic bo_lo_done;
  logic bo_lo_cond;

  blsup_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign bo_lo_cond = vs_below_bo_lo_i && !vs_above_bo_hi_i;

  blsup_qual_timer #(.DLY_CYC(BO_DLY_CYC)) u_bo_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (bo_qual_en),
    .cond_i (bo_lo_cond),
    .done_o (bo_lo_done)
  );

  blsup_bo_fsm u_bo_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .above_hi_i (vs_above_bo_hi_i),
    .lo_done_i  (bo_lo_done),
    .at_skip_i  (ctrl_at_skip_i),
    .qual_en_o  (bo_qual_en),
    .flag_o     (bo_flag_o),
    .dis_o      (ctrl_dis_en_o),
    .stop_o     (sw_stop_o)
  );

  blsup_line_range #(.LL_DLY_CYC(LL_DLY_CYC)) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .above_hl_i  (vs_above_hl_i),
    .below_ll_i  (vs_below_ll_i),
    .high_line_o (high_line_o)
  );
endmodule

// File: tb/blsup_top_tb.sv
module blsup_top_tb;
  localparam int unsigned BO_D = 8;
  localparam int unsigned LL_D = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic hi, lo, hl, ll, skip;
  logic flag, dis, stop, hline;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  flag;
    logic  dis;
    logic  stop;
    logic  hl;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  blsup_top #(.BO_DLY_CYC(BO_D), .LL_DLY_CYC(LL_D)) u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .vs_above_bo_hi_i (hi),
    .vs_below_bo_lo_i (lo),
    .vs_above_hl_i    (hl),
    .vs_below_ll_i    (ll),
    .ctrl_at_skip_i   (skip),
    .bo_flag_o        (flag),
    .ctrl_dis_en_o    (dis),
    .sw_stop_o        (stop),
    .high_line_o      (hline)
  );

  task automatic cmp(input string tag, input logic ef, ed, es, eh);
    checks++;
    if ({flag, dis, stop, hline} !== {ef, ed, es, eh}) begin
      fails++;
      $display("FAIL %s: got flag/dis/stop/hl=%b%b%b%b expected %b%b%b%b",
               tag, flag, dis, stop, hline, ef, ed, es, eh);
    end
  endtask

  // driver: one stimulus per clock, expected outputs after the next edge
  task automatic step(input logic i_hi, i_lo, i_skip, i_hl, i_ll,
                      input logic ef, ed, es, eh, input string tag);
    exp_t e;
    @(negedge clk);
    hi = i_hi; lo = i_lo; skip = i_skip; hl = i_hl; ll = i_ll;
    e.flag = ef; e.dis = ed; e.stop = es; e.hl = eh; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      cmp(e.tag, e.flag, e.dis, e.stop, e.hl);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hi = 0; lo = 0; skip = 0; hl = 0; ll = 0;
    repeat (3) @(negedge clk);
    cmp("R1 in reset", 1, 0, 1, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1 after release", 1, 0, 1, 1);

    // skip while blocked: nothing changes
    step(0, 0, 1, 0, 0, 1, 0, 1, 1, "R1 blocked idle");
    // R2 brown-in
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R2 brown-in");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 hold");
    // R6 skip ignored in run
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R6 skip in run");
    // R3 / R4 qualification with an interruption
    for (int i = 0; i < BO_D - 1; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R3 below one short");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R4 break");
    for (int i = 0; i < BO_D - 1; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R4 restarted count");
    step(0, 1, 0, 0, 0, 1, 1, 0, 1, "R3 flag and discharge");
    // R5 ramp holds without skip
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 1, 1, 0, 1, "R5 ramp no stop");
    // R7 recover during ramp
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R7 recover");
    for (int i = 0; i < BO_D - 1; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R3 second run");
    step(0, 1, 0, 0, 0, 1, 1, 0, 1, "R3 second ramp");
    // R5 skip stops switching
    step(0, 0, 1, 0, 0, 1, 0, 1, 1, "R5 stop at skip");
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, "R5 stays stopped");

    // R9 low-line qualification with an interruption
    for (int i = 0; i < LL_D - 1; i++) step(0, 0, 0, 0, 1, 1, 0, 1, 1, "R9 below one short");
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, "R9 break");
    for (int i = 0; i < LL_D - 1; i++) step(0, 0, 0, 0, 1, 1, 0, 1, 1, "R9 restarted count");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, "R9 low line");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1, 0, 1, 0, "R9 ll inert in low");
    // R8 immediate high line, precedence over low input
    step(0, 0, 0, 1, 1, 1, 0, 1, 1, "R8 high line");
    for (int i = 0; i < LL_D - 1; i++) step(0, 0, 0, 1, 1, 1, 0, 1, 1, "R8 precedence");
    for (int i = 0; i < LL_D - 1; i++) step(0, 0, 0, 0, 1, 1, 0, 1, 1, "R9 count again");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, "R9 low again");
    step(0, 0, 0, 1, 0, 1, 0, 1, 1, "R8 back high");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule